// File: doc/BRIEF.md
# Flag Threshold Register Loader

This block keeps the two thresholds that a FIFO's programmable flag logic compares against: the almost-empty distance and the almost-full distance. Each threshold is wider than the FIFO data bus, so it is stored as two fields: a low field eight bits wide and a high field that holds the remaining bits. The four fields are written from the FIFO input bus one after another. A circular selector in the write-clock domain chooses which field the next load goes into.

A second circular selector, in the read-clock domain, walks the same four fields in the same order and puts them on a registered read-back bus. The assembled thresholds go out continuously to the flag logic. Both selectors keep their position when a load or read-back sequence stops part way, so a later sequence carries on from the next field. The same load-control and write-enable pins also decide when an ordinary FIFO write takes place, and that decode goes out as a strobe. The thresholds are assumed to stay fixed while the flag logic uses them, so no synchronizer is placed between the two clock domains.

Top module: `ofs_loader`

## Requirements
- R1: When synchronous reset is released, both thresholds equal DEF_OFS (7): each low field holds 0x07 and each high field holds 0. The read-back bus is 0, and both selectors point at the almost-empty low field.
- R2: With ld_n=0 and wen_n=0, each rising wr_clk edge stores din into the selected field and then advances the write selector. The field order is almost-empty low, almost-empty high, almost-full low, almost-full high. A single load changes exactly one field.
- R3: The load after the almost-full high field wraps round to the almost-empty low field.
- R4: A load sequence can be stopped after any number of fields by raising ld_n. The next load continues with the field that follows the last one written.
- R5: With ld_n=0 and wen_n=1, a wr_clk edge changes no field and does not move the write selector.
- R6: With ld_n=1 and wen_n=0, fifo_wr is 1 and no field changes. In every other input combination, and during reset, fifo_wr is 0.
- R7: With ld_n=0, ren1_n=0 and ren2_n=0, each rising rd_clk edge loads the selected field into rd_data, zero-extended, and then advances the read selector. The read selector uses the same order and wrap as R2 and R3. rd_data bits at and above bit 8 are always 0.
- R8: If ld_n=1 or either read enable is 1, rd_data and the read selector hold their values.
- R9: A high field keeps only din[4:0] (OFS_W-8 bits). The din bits above those are dropped, and a low field keeps din[7:0].
- R10: empty_ofs = {almost-empty high, almost-empty low} and full_ofs = {almost-full high, almost-full low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock; loads happen on its rising edge |
| rd_clk | input | 1 | Read-side clock; read-back happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| ld_n | input | 1 | Active-low threshold access select |
| wen_n | input | 1 | Active-low write enable |
| ren1_n | input | 1 | Active-low read enable, first of two |
| ren2_n | input | 1 | Active-low read enable, second of two |
| din | input | DATA_W (9) | FIFO input data bus, the source of loads |
| rd_data | output | DATA_W (9) | Registered read-back of the selected field |
| empty_ofs | output | OFS_W (13) | Assembled almost-empty threshold |
| full_ofs | output | OFS_W (13) | Assembled almost-full threshold |
| fifo_wr | output | 1 | Strobe for an ordinary FIFO write |

## Verification
On every cycle the assertions check four things: reset values, that no field moves unless a load is decoded, that a load touches at most one field, and that rd_data holds when no read-back is decoded and its upper bits are always zero. Only the bench scenarios can show that fields are filled in the right order and that the selector wraps. The same holds for resuming a load stopped part way, dropping the upper din bits, the read-back order, and reset returning each selector to the first field.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  // Field order is behaviour: loads and read-back both walk it in this order.
  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } ofs_sel_e;

  localparam int NUM_FIELDS = 4;

  function automatic ofs_sel_e sel_next(input ofs_sel_e cur);
    return ofs_sel_e'(cur + 2'd1);
  endfunction

endpackage

// File: rtl/ofs_ring_sel.sv
module ofs_ring_sel
  import ofs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  output ofs_sel_e sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= SEL_E_LO;
    end else if (step) begin
      sel <= sel_next(sel);
    end
  end

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
  import ofs_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int LSB_W   = 8,
  parameter int MSB_W   = 5,
  parameter int DEF_OFS = 7
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  ofs_sel_e                         sel,
  input  logic [DATA_W-1:0]                din,
  output logic [NUM_FIELDS-1:0][LSB_W-1:0] fields
);

  localparam int OFS_W = LSB_W + MSB_W;
  localparam logic [OFS_W-1:0] DEF_V  = OFS_W'(DEF_OFS);
  localparam logic [LSB_W-1:0] DEF_LO = DEF_V[LSB_W-1:0];
  localparam logic [LSB_W-1:0] DEF_HI = LSB_W'(DEF_V[OFS_W-1:LSB_W]);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    // Odd slots are the narrow high fields; even slots are full low fields.
    localparam int                W     = (i % 2 == 1) ? MSB_W : LSB_W;
    localparam logic [LSB_W-1:0]  RST_V = (i % 2 == 1) ? DEF_HI : DEF_LO;

    always_ff @(posedge clk) begin
      if (rst) begin
        fields[i] <= RST_V;
      end else if (we && (sel == ofs_sel_e'(i))) begin
        fields[i] <= LSB_W'(din[W-1:0]);
      end
    end
  end

endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int LSB_W  = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             go,
  input  ofs_sel_e                         sel,
  input  logic [NUM_FIELDS-1:0][LSB_W-1:0] fields,
  output logic [DATA_W-1:0]                q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (go) begin
      q <= DATA_W'(fields[sel]);
    end
  end

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int OFS_W   = 13,
  parameter int DEF_OFS = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              ld_n,
  input  logic              wen_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              fifo_wr
);

  localparam int LSB_W = 8;
  localparam int MSB_W = OFS_W - LSB_W;

  logic                             ld_go;
  logic                             rb_go;
  ofs_sel_e                         wsel;
  ofs_sel_e                         rsel;
  logic [NUM_FIELDS-1:0][LSB_W-1:0] fields;

  assign ld_go   = !ld_n && !wen_n;
  assign rb_go   = !ld_n && !ren1_n && !ren2_n;
  assign fifo_wr = !rst && ld_n && !wen_n;

  ofs_ring_sel u_wsel (
    .clk  (wr_clk),
    .rst  (rst),
    .step (ld_go),
    .sel  (wsel)
  );

  ofs_ring_sel u_rsel (
    .clk  (rd_clk),
    .rst  (rst),
    .step (rb_go),
    .sel  (rsel)
  );

  ofs_bank #(
    .DATA_W  (DATA_W),
    .LSB_W   (LSB_W),
    .MSB_W   (MSB_W),
    .DEF_OFS (DEF_OFS)
  ) u_bank (
    .clk    (wr_clk),
    .rst    (rst),
    .we     (ld_go),
    .sel    (wsel),
    .din    (din),
    .fields (fields)
  );

  ofs_rd_port #(
    .DATA_W (DATA_W),
    .LSB_W  (LSB_W)
  ) u_rd (
    .clk    (rd_clk),
    .rst    (rst),
    .go     (rb_go),
    .sel    (rsel),
    .fields (fields),
    .q      (rd_data)
  );

  assign empty_ofs = {fields[SEL_E_HI][MSB_W-1:0], fields[SEL_E_LO]};
  assign full_ofs  = {fields[SEL_F_HI][MSB_W-1:0], fields[SEL_F_LO]};

endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
  parameter int DATA_W  = 9,
  parameter int OFS_W   = 13,
  parameter int DEF_OFS = 7
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst,
  input logic              ld_n,
  input logic              wen_n,
  input logic              ren1_n,
  input logic              ren2_n,
  input logic [DATA_W-1:0] rd_data,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs,
  input logic              fifo_wr
);

  localparam int LSB_W = 8;

  p_reset_thresholds_r1: assert property (@(posedge wr_clk) disable iff (rst)
    $fell(rst) |-> (empty_ofs == OFS_W'(DEF_OFS)) && (full_ofs == OFS_W'(DEF_OFS)));

  p_reset_readback_r1: assert property (@(posedge rd_clk) disable iff (rst)
    $fell(rst) |-> (rd_data == '0));

  p_one_field_per_load_r2: assert property (@(posedge wr_clk) disable iff (rst)
    1'b1 |=> ($countones({!$stable(empty_ofs[LSB_W-1:0]), !$stable(empty_ofs[OFS_W-1:LSB_W]),
                          !$stable(full_ofs[LSB_W-1:0]),  !$stable(full_ofs[OFS_W-1:LSB_W])}) <= 1));

  p_idle_keeps_fields_r5: assert property (@(posedge wr_clk) disable iff (rst)
    (ld_n || wen_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  p_fifo_wr_no_load_r6: assert property (@(posedge wr_clk) disable iff (rst)
    fifo_wr |=> ($stable(empty_ofs) && $stable(full_ofs)));

  p_rd_upper_zero_r7: assert property (@(posedge rd_clk) disable iff (rst)
    rd_data[DATA_W-1:LSB_W] == '0);

  p_rd_hold_r8: assert property (@(posedge rd_clk) disable iff (rst)
    (ld_n || ren1_n || ren2_n) |=> $stable(rd_data));

endmodule

bind ofs_loader ofs_loader_chk #(
  .DATA_W  (DATA_W),
  .OFS_W   (OFS_W),
  .DEF_OFS (DEF_OFS)
) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .rst       (rst),
  .ld_n      (ld_n),
  .wen_n     (wen_n),
  .ren1_n    (ren1_n),
  .ren2_n    (ren2_n),
  .rd_data   (rd_data),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs),
  .fifo_wr   (fifo_wr)
);

// File: tb/ofs_loader_tb.sv
module ofs_loader_tb;

  localparam int DATA_W = 9;
  localparam int OFS_W  = 13;
  localparam int NV     = 9;

  logic              wr_clk = 1'b0;
  logic              rd_clk = 1'b0;
  logic              rst    = 1'b1;
  logic              ld_n   = 1'b1;
  logic              wen_n  = 1'b1;
  logic              ren1_n = 1'b1;
  logic              ren2_n = 1'b1;
  logic [DATA_W-1:0] din    = '0;
  logic [DATA_W-1:0] rd_data;
  logic [OFS_W-1:0]  empty_ofs;
  logic [OFS_W-1:0]  full_ofs;
  logic              fifo_wr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 wr_clk = ~wr_clk;
  initial begin
    #7;
    forever #10 rd_clk = ~rd_clk;
  end

  ofs_loader u_dut (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst       (rst),
    .ld_n      (ld_n),
    .wen_n     (wen_n),
    .ren1_n    (ren1_n),
    .ren2_n    (ren2_n),
    .din       (din),
    .rd_data   (rd_data),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .fifo_wr   (fifo_wr)
  );

  // {ld_n, wen_n, din, expected empty_ofs, expected full_ofs, expected fifo_wr}
  localparam logic [37:0] TBL [NV] = '{
    {1'b0, 1'b0, 9'h1A5, 13'h00A5, 13'h0007, 1'b0},  // R2 R9: empty low keeps din[7:0]
    {1'b0, 1'b1, 9'h0FF, 13'h00A5, 13'h0007, 1'b0},  // R5: no load
    {1'b0, 1'b0, 9'h1F3, 13'h13A5, 13'h0007, 1'b0},  // R2 R9: empty high keeps din[4:0]
    {1'b1, 1'b0, 9'h055, 13'h13A5, 13'h0007, 1'b1},  // R6: fifo write, R4 pause
    {1'b0, 1'b0, 9'h03C, 13'h13A5, 13'h003C, 1'b0},  // R4: resumes at full low
    {1'b0, 1'b0, 9'h1E2, 13'h13A5, 13'h023C, 1'b0},  // R2 R10: full high
    {1'b0, 1'b0, 9'h011, 13'h1311, 13'h023C, 1'b0},  // R3: wraps to empty low
    {1'b1, 1'b1, 9'h1FF, 13'h1311, 13'h023C, 1'b0},  // R6: idle, no strobe
    {1'b0, 1'b0, 9'h0FF, 13'h1F11, 13'h023C, 1'b0}   // R9: empty high upper bits dropped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_step(input logic l, input logic w, input logic [DATA_W-1:0] d);
    @(negedge wr_clk);
    ld_n = l; wen_n = w; din = d;
    #1;
  endtask

  task automatic rd_step(input logic l, input logic r1, input logic r2);
    @(negedge rd_clk);
    ld_n = l; ren1_n = r1; ren2_n = r2; wen_n = 1'b1;
    @(posedge rd_clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    rst = 1'b1; ld_n = 1'b1; wen_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    repeat (3) @(posedge wr_clk);
    repeat (3) @(posedge rd_clk);
    @(negedge wr_clk);
    rst = 1'b0;
    @(posedge wr_clk);
    @(posedge rd_clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 empty_ofs", 32'(empty_ofs), 32'h7);
    chk("R1 full_ofs", 32'(full_ofs), 32'h7);
    chk("R1 rd_data", 32'(rd_data), 32'h0);
    chk("R6 fifo_wr idle", 32'(fifo_wr), 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr_step(TBL[i][37], TBL[i][36], TBL[i][35:27]);
      chk("R6 fifo_wr decode", 32'(fifo_wr), 32'(TBL[i][0]));
      @(posedge wr_clk);
      #1;
      chk("R2 R10 empty_ofs", 32'(empty_ofs), 32'(TBL[i][26:14]));
      chk("R2 R10 full_ofs", 32'(full_ofs), 32'(TBL[i][13:1]));
    end
    wr_step(1'b1, 1'b1, '0);

    // Read-back: fields are 0x11, 0x1F, 0x3C, 0x02.
    rd_step(1'b0, 1'b0, 1'b0);
    chk("R7 read empty low", 32'(rd_data), 32'h011);
    rd_step(1'b0, 1'b0, 1'b0);
    chk("R7 read empty high", 32'(rd_data), 32'h01F);
    rd_step(1'b0, 1'b0, 1'b1);
    chk("R8 hold ren2_n high", 32'(rd_data), 32'h01F);
    rd_step(1'b0, 1'b1, 1'b0);
    chk("R8 hold ren1_n high", 32'(rd_data), 32'h01F);
    rd_step(1'b0, 1'b0, 1'b0);
    chk("R7 read full low", 32'(rd_data), 32'h03C);
    rd_step(1'b1, 1'b0, 1'b0);
    chk("R8 hold ld_n high", 32'(rd_data), 32'h03C);
    rd_step(1'b0, 1'b0, 1'b0);
    chk("R7 read full high", 32'(rd_data), 32'h002);
    rd_step(1'b0, 1'b0, 1'b0);
    chk("R7 wrap to empty low", 32'(rd_data), 32'h011);
    rd_step(1'b1, 1'b1, 1'b1);

    // Reset mid-sequence returns values and both selectors to the first field.
    do_reset();
    chk("R1 empty_ofs after re-reset", 32'(empty_ofs), 32'h7);
    chk("R1 full_ofs after re-reset", 32'(full_ofs), 32'h7);
    chk("R1 rd_data after re-reset", 32'(rd_data), 32'h0);
    rd_step(1'b0, 1'b0, 1'b0);
    chk("R1 read selector at empty low", 32'(rd_data), 32'h007);
    rd_step(1'b1, 1'b1, 1'b1);
    wr_step(1'b0, 1'b0, 9'h144);
    @(posedge wr_clk);
    #1;
    chk("R1 write selector at empty low", 32'(empty_ofs), 32'h0044);
    chk("R1 full untouched", 32'(full_ofs), 32'h0007);
    wr_step(1'b0, 1'b0, 9'h1FF);
    @(posedge wr_clk);
    #1;
    chk("R9 high field max", 32'(empty_ofs), 32'h1F44);
    wr_step(1'b1, 1'b1, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule